// File: doc/BRIEF.md
# Cascadable Loadable Binary Counter

This block is a synchronous binary counter assembled from identical 4-bit slices. Each slice has a register with an asynchronous active-low clear and a synchronous active-low parallel load. It also has two count enables that do not play the same role. The first is a shared "parallel" enable. The second is a "trickle" enable, which is the only one that feeds the slice's carry output.

A parameterised top chains `NUM_SLICES` slices into one counter of `4*NUM_SLICES` bits:

- Every slice sees the same clear, load and parallel enable.
- The trickle enable of slice 0 is the external trickle enable.
- The trickle enable of each higher slice is the carry of the slice below it.

An upper slice therefore advances on the same clock edge on which every lower slice wraps, and no extra gating is needed to do it. The carry of the last slice is the counter's carry output. Further counters can be cascaded from it in the same way.

Load wins over both enables. Clear wins over everything else and takes effect at once, without waiting for a clock edge. The carry output is combinational. It is high only when every count bit is 1 and the external trickle enable is high. It does not depend on the parallel enable.

Top module: `cascade_counter`

## Requirements
- R1: While `clrN` is 0, `countOut` and `carryOut` are 0 immediately, with no clock edge needed. Load and both enables are ignored while `clrN` is 0.
- R2: When `clrN` is 1 and `loadN` is 0, a rising edge of `clk` copies `dataIn` into `countOut`, whatever the values of `enP` and `enT`.
- R3: When `clrN`, `loadN`, `enP` and `enT` are all 1, each rising edge of `clk` adds one to `countOut`, treated as a single unsigned binary number.
- R4: When `loadN` is 1 and either `enP` or `enT` is 0, rising edges of `clk` leave `countOut` unchanged.
- R5: `carryOut` is 1 exactly when every bit of `countOut` is 1 and `enT` is 1. It follows `enT` combinationally and does not depend on `enP`.
- R6: While `enT` is 0, `carryOut` is 0 whatever the count value.
- R7: Counting from all ones (`countOut` = 2^(4*NUM_SLICES)-1) gives all zeros on the next counting edge.
- R8: Slice k (bits 4k+3..4k) advances on the same edge on which bits 4k-1..0 roll over from all ones. For example, with 3 slices, 0x0FF counts to 0x100 in a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising-edge active |
| clrN | input | 1 | Asynchronous clear, active low |
| loadN | input | 1 | Synchronous parallel load, active low |
| enP | input | 1 | Parallel count enable, shared by all slices |
| enT | input | 1 | Trickle count enable into slice 0; also gates carryOut |
| dataIn | input | 4*NUM_SLICES | Parallel load value |
| countOut | output | 4*NUM_SLICES | Current count |
| carryOut | output | 1 | High when the count is all ones and enT is high |

## Verification
The bench drives a clear in the middle of a clock period, while the count is all ones and the carry is high. It then checks that both outputs fall before the next edge. A design that made the clear synchronous would keep the old count until that edge.

The bench also holds the count at all ones and toggles each enable on its own, with no clock edge. A carry wrongly gated by the parallel enable, or one taken from a register, shows up here as a wrong or late carry.

Slice-boundary steps such as 0x0FF to 0x100 and 0x7FF to 0x800, together with the wrap from all ones to zero, expose a lookahead chain that is delayed by a cycle. They also expose a chain that lets an upper slice count early.

Finally, loads made with both enables high check the load priority, and edges made with either enable low check the hold behaviour.

// File: rtl/cascade_cnt_pkg.sv
package cascade_cnt_pkg;

  // Bits held by one counter slice.
  localparam int SLICE_W = 4;

  // Strobes from a slice's control to its datapath.
  typedef struct packed {
    logic loadEn;   // take the parallel input on this edge
    logic incEn;    // add one on this edge
  } sliceStrobe_t;

endpackage

// File: rtl/cnt_slice_ctrl.sv
module cnt_slice_ctrl
  import cascade_cnt_pkg::*;
(
  input  logic         loadN,
  input  logic         enP,
  input  logic         enT,
  output sliceStrobe_t strobe
);

  // Load has priority; counting needs both enables and no load.
  always_comb begin
    strobe.loadEn = ~loadN;
    strobe.incEn  = loadN & enP & enT;
  end

endmodule

// File: rtl/cnt_slice_dp.sv
module cnt_slice_dp
  import cascade_cnt_pkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic         clk,
  input  logic         clrN,
  input  sliceStrobe_t strobe,
  input  logic         enT,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] q,
  output logic         carry
);

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      q <= '0;
    end else if (strobe.loadEn) begin
      q <= dIn;
    end else if (strobe.incEn) begin
      q <= q + W'(1);
    end
  end

  // Lookahead carry: only the trickle enable gates it.
  assign carry = (&q) & enT;

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cascade_cnt_pkg::*;
#(
  parameter int NUM_SLICES = 3
) (
  input  logic                          clk,
  input  logic                          clrN,
  input  logic                          loadN,
  input  logic                          enP,
  input  logic                          enT,
  input  logic [NUM_SLICES*SLICE_W-1:0] dataIn,
  output logic [NUM_SLICES*SLICE_W-1:0] countOut,
  output logic                          carryOut
);

  localparam int CNT_W = NUM_SLICES * SLICE_W;

  // trickleChain[k] is the trickle enable of slice k.
  logic [NUM_SLICES:0] trickleChain;
  assign trickleChain[0] = enT;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    sliceStrobe_t strobe;

    cnt_slice_ctrl u_ctrl (
      .loadN  (loadN),
      .enP    (enP),
      .enT    (trickleChain[k]),
      .strobe (strobe)
    );

    cnt_slice_dp #(.W(SLICE_W)) u_dp (
      .clk    (clk),
      .clrN   (clrN),
      .strobe (strobe),
      .enT    (trickleChain[k]),
      .dIn    (dataIn[k*SLICE_W +: SLICE_W]),
      .q      (countOut[k*SLICE_W +: SLICE_W]),
      .carry  (trickleChain[k+1])
    );
  end

  assign carryOut = trickleChain[NUM_SLICES];

endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             clrN,
  input logic             loadN,
  input logic             enP,
  input logic             enT,
  input logic [CNT_W-1:0] dataIn,
  input logic [CNT_W-1:0] countOut,
  input logic             carryOut
);

  always @(negedge clk) begin
    if (clrN === 1'b0) begin
      AST_CLEAR_ZERO: assert (countOut == '0 && !carryOut)
        else $error("clear did not zero the counter"); // R1
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clrN)
    !loadN |=> countOut == $past(dataIn)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clrN)
    (loadN && enP && enT) |=> countOut == $past(countOut) + CNT_W'(1)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clrN)
    (loadN && !(enP && enT)) |=> $stable(countOut)); // R4

  AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!clrN)
    carryOut |-> (&countOut)); // R5

  AST_CARRY_TRICKLE: assert property (@(posedge clk) disable iff (!clrN)
    !enT |-> !carryOut); // R6

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clrN)
    ((&countOut) && loadN && enP && enT) |=> countOut == '0); // R7

endmodule

bind cascade_counter cascade_counter_chk #(.CNT_W(NUM_SLICES*4)) u_chk (
  .clk      (clk),
  .clrN     (clrN),
  .loadN    (loadN),
  .enP      (enP),
  .enT      (enT),
  .dataIn   (dataIn),
  .countOut (countOut),
  .carryOut (carryOut)
);

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;

  localparam int CLK_PERIOD = 10;
  localparam int NSL = 3;
  localparam int W = 12;
  localparam int NVEC = 14;

  logic         clk = 1'b0;
  logic         clrN;
  logic         loadN;
  logic         enP;
  logic         enT;
  logic [W-1:0] dataIn;
  logic [W-1:0] countOut;
  logic         carryOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  cascade_counter #(.NUM_SLICES(NSL)) dut (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enP(enP), .enT(enT),
    .dataIn(dataIn), .countOut(countOut), .carryOut(carryOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector layout: {loadN, enP, enT, dataIn[11:0], expCount[11:0], expCarry}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 12'h0FE, 12'h0FE, 1'b0},  // R2 load
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h0FF, 1'b0},  // R3 count
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h100, 1'b0},  // R8 slice step
    {1'b1, 1'b0, 1'b1, 12'h000, 12'h100, 1'b0},  // R4 enP low
    {1'b1, 1'b1, 1'b0, 12'h000, 12'h100, 1'b0},  // R4 enT low
    {1'b0, 1'b1, 1'b1, 12'hFFE, 12'hFFE, 1'b0},  // R2 load over enables
    {1'b1, 1'b1, 1'b1, 12'h000, 12'hFFF, 1'b1},  // R5 carry high
    {1'b1, 1'b0, 1'b1, 12'h000, 12'hFFF, 1'b1},  // R5 carry ignores enP
    {1'b1, 1'b1, 1'b0, 12'h000, 12'hFFF, 1'b0},  // R6 enT gates carry
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h000, 1'b0},  // R7 wrap
    {1'b0, 1'b0, 1'b0, 12'h5A3, 12'h5A3, 1'b0},  // R2 load
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h5A4, 1'b0},  // R3 count
    {1'b0, 1'b0, 1'b1, 12'h7FF, 12'h7FF, 1'b0},  // R2 load
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h800, 1'b0}   // R8 two-slice step
  };

  task automatic checkCount(string req, logic [W-1:0] exp);
    checks++;
    if (countOut !== exp) begin
      failures++;
      $display("FAIL %s countOut actual=%h expected=%h", req, countOut, exp);
    end
  endtask

  task automatic checkCarry(string req, logic exp);
    checks++;
    if (carryOut !== exp) begin
      failures++;
      $display("FAIL %s carryOut actual=%b expected=%b", req, carryOut, exp);
    end
  endtask

  initial begin
    clrN = 1'b0; loadN = 1'b1; enP = 1'b0; enT = 1'b0; dataIn = '0;
    repeat (2) @(negedge clk);
    checkCount("R1", 12'h000);
    checkCarry("R1", 1'b0);
    clrN = 1'b1;

    // Table walk: apply at a falling edge, check at the next falling edge.
    for (int i = 0; i < NVEC; i++) begin
      {loadN, enP, enT, dataIn} = VEC[i][27:13];
      @(negedge clk);
      checkCount($sformatf("vec%0d", i), VEC[i][12:1]);
      checkCarry($sformatf("vec%0d", i), VEC[i][0]);
    end

    // R5 / R6: carry follows enT between edges; enP has no effect.
    loadN = 1'b0; enP = 1'b0; enT = 1'b0; dataIn = 12'hFFF;
    @(negedge clk);
    loadN = 1'b1;
    checkCarry("R6", 1'b0);
    enT = 1'b1; #1;
    checkCarry("R5", 1'b1);
    enP = 1'b1; enT = 1'b0; #1;
    checkCarry("R6", 1'b0);
    checkCount("R4", 12'hFFF);

    // R1: clear between edges, reference model goes to zero at once.
    enP = 1'b0; enT = 1'b1; #1;
    checkCarry("R5", 1'b1);
    @(posedge clk);
    #(CLK_PERIOD/4);
    clrN = 1'b0; #1;
    checkCount("R1", 12'h000);
    checkCarry("R1", 1'b0);

    // R1: load and count are ignored while clear is held.
    loadN = 1'b0; enP = 1'b1; enT = 1'b1; dataIn = 12'hABC;
    @(negedge clk); @(negedge clk);
    checkCount("R1", 12'h000);
    checkCarry("R1", 1'b0);

    // Release clear and count from zero.
    loadN = 1'b1; clrN = 1'b1;
    @(negedge clk);
    checkCount("R3", 12'h001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule